// File: doc/BRIEF.md
# Flash Command Interpreter

This block models the command logic of a byte-wide NOR-style flash device whose asynchronous bus (chip enable, output enable, write enable, address, 8-bit data) has already been sampled into the local clock domain. Writes on that bus are not stored directly. They are treated as bus cycles of keyed command sequences. Each sequence opens with two unlock writes to fixed key addresses. The sequence then selects one operation: byte program, chip erase, permanent boot-region lockout, or entry into and exit from product-identification mode.

The storage is a small parameterized byte array that comes out of reset fully erased (all ones). Programming can only clear bits. Program and erase run for a fixed number of clock cycles, set by parameters. During that time the block raises `busy`, ignores every write, and answers all reads with a status byte. In that byte, bit 7 is the data-polling bit and bit 6 is a toggle bit. A boot region of 2^BOOT_W bytes sits at the bottom of the array, or at the top when TOP_BOOT is set. Once the lockout command has run, that region is protected from both program and erase until reset.

The state machine uses these states:
- ST_READ: idle array reads.
- ST_KEY1 and ST_KEY2: the first and second unlock writes have been seen.
- ST_PROG_ARM: waiting for the program address and data.
- ST_EXT3, ST_EXT4, ST_EXT5: the extended prefix used for erase and lock.
- ST_ID, ST_IDX1, ST_IDX2: identification mode and its keyed exit.
- ST_PROG_RUN and ST_ERASE_RUN: the timed operations.

Transitions:
- The unlock writes step ST_READ→ST_KEY1→ST_KEY2.
- In ST_KEY2, code A0h leads to ST_PROG_ARM, 80h to ST_EXT3 and 90h to ST_ID.
- In ST_PROG_ARM, any write leads to ST_PROG_RUN.
- The second unlock pair steps ST_EXT3→ST_EXT4→ST_EXT5.
- In ST_EXT5, code 10h leads to ST_ERASE_RUN. Code 40h sets the lock and returns to ST_READ.
- The exit keys step ST_ID→ST_IDX1→ST_IDX2. Any write in ST_IDX2 leads to ST_READ.
- ST_PROG_RUN and ST_ERASE_RUN return to ST_READ when the timer expires.
- Any unexpected write in any other state leads to ST_READ.

Top module: `flash_cmd_top`

## Requirements
- R1: A write is taken only in the first clock cycle in which ce_n=0, we_n=0 and oe_n=1 all hold. A cycle with oe_n=0 takes no write. A read is driven only while ce_n=0, oe_n=0 and we_n=1. Otherwise rdata_oe=0 and rdata=00h.
- R2: After reset the array holds FFh at every address, lockout is off, busy=0, and in read mode a read returns the byte stored at addr.
- R3: Every sequence opens with AAh written to key address A and then 55h written to key address B. Key A is the low min(ADDR_W,15) bits of 5555h and key B the same bits of 2AAAh; only those address bits are compared. A write that does not continue the expected sequence returns to read mode and changes no byte.
- R4: A third write of A0h to key A arms a program. The next write gives the target address and data, and after the program time the stored byte becomes old AND new.
- R5: The six-write sequence AAh@A, 55h@B, 80h@A, AAh@A, 55h@B, 10h@A erases, leaving FFh in every byte outside a locked boot region.
- R6: The same six-write sequence ending in 40h@A sets lockout at once, with no busy period, and it stays set until reset. The boot region is the addresses whose upper ADDR_W-BOOT_W bits are all zero (all one when TOP_BOOT=1). While lockout is set, program and erase leave that region unchanged.
- R7: The third write 90h@A enters identification mode. In that mode, reads of address 0 return 1Fh, address 1 returns 13h (bottom boot) or 12h (top boot), address 2 returns the lockout flag in bit 0, and every other address returns 00h.
- R8: Identification mode ends on a single write of F0h to any address, on the sequence AAh@A, 55h@B, F0h@A, or on any write that breaks that sequence. None of these changes the array.
- R9: While busy, every read returns a status byte. Bit 7 is the complement of the loaded data bit 7 during a program and 0 during an erase. Bit 6 inverts after each completed read. Bits 5..0 are 0.
- R10: Writes that arrive while busy=1 are ignored, including one in the last busy cycle.
- R11: busy is high for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase, starting in the cycle after the write that starts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; erases the array and clears lockout |
| ce_n | input | 1 | Sampled chip enable, active low |
| oe_n | input | 1 | Sampled output enable, active low |
| we_n | input | 1 | Sampled write enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data / command code |
| rdata | output | 8 | Read data, status byte or identification code |
| rdata_oe | output | 1 | High while a read drives rdata |
| busy | output | 1 | High while a program or erase is timed |

## Verification
The interaction of interest is a write strobe that lands in the final busy cycle of a program, the same cycle in which the timer completes and the byte is committed.

The bench starts a program, counts exactly PROG_CYC-1 cycles, and places the first unlock write of an identification entry so that it is sampled on that last busy edge. It then completes the rest of the entry sequence. If the late write was correctly dropped, address 0 reads back the array byte rather than 1Fh. The bench also confirms that the programmed byte landed.

The same experiment shifted one cycle later must be accepted, and the identification code must appear.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_KEY1,
        ST_KEY2,
        ST_PROG_ARM,
        ST_EXT3,
        ST_EXT4,
        ST_EXT5,
        ST_ID,
        ST_IDX1,
        ST_IDX2,
        ST_PROG_RUN,
        ST_ERASE_RUN
    } cmd_state_t;

    localparam logic [7:0] CODE_KEY1  = 8'hAA;
    localparam logic [7:0] CODE_KEY2  = 8'h55;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_EXT   = 8'h80;
    localparam logic [7:0] CODE_ID    = 8'h90;
    localparam logic [7:0] CODE_EXIT  = 8'hF0;
    localparam logic [7:0] CODE_ERASE = 8'h10;
    localparam logic [7:0] CODE_LOCK  = 8'h40;

    localparam logic [7:0] ID_MAKER   = 8'h1F;
    localparam logic [7:0] ID_BOTTOM  = 8'h13;
    localparam logic [7:0] ID_TOP     = 8'h12;

    localparam logic [14:0] KEY_ADDR_A = 15'h5555;
    localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;

endpackage

// File: rtl/flash_bus_sampler.sv
`timescale 1ns/1ps
module flash_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_evt,
    output logic rd_on,
    output logic rd_done
);
    logic wr_lvl;
    logic wr_q;
    logic rd_q;

    assign wr_lvl  = !ce_n && !we_n && oe_n;
    assign rd_on   = !ce_n && !oe_n && we_n;
    assign wr_evt  = wr_lvl && !wr_q;
    assign rd_done = rd_q && !rd_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_lvl;
            rd_q <= rd_on;
        end
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PROG_CYC  = 20,
    parameter int ERASE_CYC = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              busy,
    output logic              prog_run,
    output logic              id_mode,
    output logic              prog_go,
    output logic              erase_go,
    output logic              lock_go,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [7:0]        tgt_data
);
    localparam int CMP_W   = (ADDR_W < 15) ? ADDR_W : 15;
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;
    localparam logic [CMP_W-1:0] KEY_A = KEY_ADDR_A[CMP_W-1:0];
    localparam logic [CMP_W-1:0] KEY_B = KEY_ADDR_B[CMP_W-1:0];

    cmd_state_t        state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic              hit_a, hit_b;
    logic              run_done;

    assign hit_a    = (addr[CMP_W-1:0] == KEY_A);
    assign hit_b    = (addr[CMP_W-1:0] == KEY_B);
    assign run_done = (cnt == '0);

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_READ:
                if (wr_evt && hit_a && wdata == CODE_KEY1) nxt = ST_KEY1;
            ST_KEY1:
                if (wr_evt) nxt = (hit_b && wdata == CODE_KEY2) ? ST_KEY2 : ST_READ;
            ST_KEY2:
                if (wr_evt) begin
                    nxt = ST_READ;
                    if (hit_a) begin
                        if (wdata == CODE_PROG)     nxt = ST_PROG_ARM;
                        else if (wdata == CODE_EXT) nxt = ST_EXT3;
                        else if (wdata == CODE_ID)  nxt = ST_ID;
                    end
                end
            ST_PROG_ARM:
                if (wr_evt) nxt = ST_PROG_RUN;
            ST_EXT3:
                if (wr_evt) nxt = (hit_a && wdata == CODE_KEY1) ? ST_EXT4 : ST_READ;
            ST_EXT4:
                if (wr_evt) nxt = (hit_b && wdata == CODE_KEY2) ? ST_EXT5 : ST_READ;
            ST_EXT5:
                if (wr_evt) nxt = (hit_a && wdata == CODE_ERASE) ? ST_ERASE_RUN : ST_READ;
            ST_ID:
                if (wr_evt) nxt = (hit_a && wdata == CODE_KEY1) ? ST_IDX1 : ST_READ;
            ST_IDX1:
                if (wr_evt) nxt = (hit_b && wdata == CODE_KEY2) ? ST_IDX2 : ST_READ;
            ST_IDX2:
                if (wr_evt) nxt = ST_READ;
            ST_PROG_RUN:
                if (run_done) nxt = ST_READ;
            ST_ERASE_RUN:
                if (run_done) nxt = ST_READ;
            default:
                nxt = ST_READ;
        endcase
    end

    // state register, timer and program latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_READ;
            cnt      <= '0;
            tgt_addr <= '0;
            tgt_data <= '0;
        end else begin
            state <= nxt;
            if (state != ST_PROG_RUN && nxt == ST_PROG_RUN)
                cnt <= CNT_W'(PROG_CYC - 1);
            else if (state != ST_ERASE_RUN && nxt == ST_ERASE_RUN)
                cnt <= CNT_W'(ERASE_CYC - 1);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
            if (state == ST_PROG_ARM && wr_evt) begin
                tgt_addr <= addr;
                tgt_data <= wdata;
            end
        end
    end

    // outputs
    always_comb begin
        prog_run = (state == ST_PROG_RUN);
        busy     = (state == ST_PROG_RUN) || (state == ST_ERASE_RUN);
        id_mode  = (state == ST_ID) || (state == ST_IDX1) || (state == ST_IDX2);
        prog_go  = (state == ST_PROG_RUN) && run_done;
        erase_go = (state == ST_ERASE_RUN) && run_done;
        lock_go  = (state == ST_EXT5) && wr_evt && hit_a && (wdata == CODE_LOCK);
    end
endmodule

// File: rtl/flash_array.sv
`timescale 1ns/1ps
module flash_array
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int BOOT_W   = 4,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_go,
    input  logic              erase_go,
    input  logic              lock_go,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [7:0]        tgt_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_on,
    input  logic              rd_done,
    input  logic              busy,
    input  logic              prog_run,
    input  logic              id_mode,
    output logic [7:0]        rdata,
    output logic              lock_on
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HI_W  = ADDR_W - BOOT_W;
    localparam logic [HI_W-1:0] BOOT_TAG = TOP_BOOT ? {HI_W{1'b1}} : {HI_W{1'b0}};
    localparam logic [7:0] DEV_CODE = TOP_BOOT ? ID_TOP : ID_BOTTOM;

    logic [7:0] mem [DEPTH];
    logic       tog;

    function automatic logic shielded(input logic [ADDR_W-1:0] a, input logic lk);
        return lk && (a[ADDR_W-1 -: HI_W] == BOOT_TAG);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            lock_on <= 1'b0;
            tog     <= 1'b0;
        end else begin
            if (rd_done) tog <= ~tog;
            if (lock_go) lock_on <= 1'b1;
            if (prog_go && !shielded(tgt_addr, lock_on))
                mem[tgt_addr] <= mem[tgt_addr] & tgt_data;
            if (erase_go) begin
                for (int i = 0; i < DEPTH; i++)
                    if (!shielded(ADDR_W'(i), lock_on)) mem[i] <= 8'hFF;
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (rd_on) begin
            if (busy)
                rdata = {prog_run ? ~tgt_data[7] : 1'b0, tog, 6'b0};
            else if (id_mode) begin
                if (rd_addr == ADDR_W'(0))      rdata = ID_MAKER;
                else if (rd_addr == ADDR_W'(1)) rdata = DEV_CODE;
                else if (rd_addr == ADDR_W'(2)) rdata = {7'b0, lock_on};
            end else
                rdata = mem[rd_addr];
        end
    end
endmodule

// File: rtl/flash_cmd_top.sv
`timescale 1ns/1ps
module flash_cmd_top #(
    parameter int ADDR_W    = 8,
    parameter int BOOT_W    = 4,
    parameter bit TOP_BOOT  = 1'b0,
    parameter int PROG_CYC  = 20,
    parameter int ERASE_CYC = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rdata_oe,
    output logic              busy
);
    logic              wr_evt, rd_on, rd_done;
    logic              prog_run, id_mode, prog_go, erase_go, lock_go, lock_on;
    logic [ADDR_W-1:0] tgt_addr;
    logic [7:0]        tgt_data;

    flash_bus_sampler u_bus (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wr_evt(wr_evt), .rd_on(rd_on), .rd_done(rd_done)
    );

    flash_cmd_fsm #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .addr(addr), .wdata(wdata),
        .busy(busy), .prog_run(prog_run), .id_mode(id_mode),
        .prog_go(prog_go), .erase_go(erase_go), .lock_go(lock_go),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data)
    );

    flash_array #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .TOP_BOOT(TOP_BOOT)) u_arr (
        .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go),
        .lock_go(lock_go), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
        .rd_addr(addr), .rd_on(rd_on), .rd_done(rd_done), .busy(busy),
        .prog_run(prog_run), .id_mode(id_mode), .rdata(rdata), .lock_on(lock_on)
    );

    assign rdata_oe = rd_on;
endmodule

// File: rtl/flash_cmd_checks.sv
`timescale 1ns/1ps
module flash_cmd_checks #(
    parameter int ADDR_W    = 8,
    parameter int ERASE_CYC = 60
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata,
    input logic              rdata_oe,
    input logic              busy,
    input logic              id_mode,
    input logic              lock_on,
    input logic              wr_evt,
    input logic              prog_go,
    input logic              erase_go
);
    int busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_len <= 0;
        else if (busy)  busy_len <= busy_len + 1;
        else            busy_len <= 0;
    end

    p_read_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || !we_n) |-> !rdata_oe);

    p_id_maker_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && rdata_oe && addr == '0) |-> (rdata == 8'h1F));

    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_on |=> lock_on);

    p_status_low_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rdata_oe) |-> (rdata[5:0] == 6'b0));

    p_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_evt && !prog_go && !erase_go) |=> busy);

    p_busy_bounded_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len <= ERASE_CYC);
endmodule

bind flash_cmd_top flash_cmd_checks #(.ADDR_W(ADDR_W), .ERASE_CYC(ERASE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .rdata(rdata), .rdata_oe(rdata_oe), .busy(busy), .id_mode(id_mode),
    .lock_on(lock_on), .wr_evt(wr_evt), .prog_go(prog_go), .erase_go(erase_go)
);

// File: tb/flash_cmd_top_test.sv
`timescale 1ns/1ps
module flash_cmd_top_test;
    localparam int ADDR_W = 8;
    localparam int BOOT_W = 4;
    localparam int PROG_CYC = 20;
    localparam int ERASE_CYC = 60;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [7:0] KA = 8'h55;
    localparam logic [7:0] KB = 8'hAA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic rdata_oe, busy;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [DEPTH];
    logic lock_m = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_top #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .TOP_BOOT(1'b0),
                    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .busy(busy)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic in_boot(input int a);
        return lock_m && (a < (1 << BOOT_W));
    endfunction

    task automatic wr_now(input logic [7:0] a, input logic [7:0] d, input logic oe);
        ce_n = 1'b0; we_n = 1'b0; oe_n = oe; addr = a; wdata = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_now(a, d, 1'b1);
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
    endtask

    task automatic prog_start(input logic [7:0] a, input logic [7:0] d);
        bus_wr(KA, 8'hAA); bus_wr(KB, 8'h55); bus_wr(KA, 8'hA0); bus_wr(a, d);
        if (!in_boot(a)) model[a] = model[a] & d;
    endtask

    task automatic ext_seq(input logic [7:0] code);
        bus_wr(KA, 8'hAA); bus_wr(KB, 8'h55); bus_wr(KA, 8'h80);
        bus_wr(KA, 8'hAA); bus_wr(KB, 8'h55); bus_wr(KA, code);
    endtask

    task automatic erase_model();
        for (int i = 0; i < DEPTH; i++) if (!in_boot(i)) model[i] = 8'hFF;
    endtask

    task automatic id_enter();
        bus_wr(KA, 8'hAA); bus_wr(KB, 8'h55); bus_wr(KA, 8'h90);
    endtask

    task automatic sweep(input string tag);
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            bus_rd(8'(i), v);
            chk(tag, v, model[i]);
        end
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        int n;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        chk("R2 busy after reset", {7'b0, busy}, 8'h00);
        chk("R1 oe idle", {7'b0, rdata_oe}, 8'h00);
        sweep("R2 erased after reset");

        // R1 read gated by chip enable
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; addr = 8'h33;
        #1 chk("R1 no read with ce_n high", {rdata_oe, rdata[6:0]}, 8'h00);
        @(negedge clk); oe_n = 1'b1;

        // R4 + R11 program timing
        prog_start(8'h40, 8'h3C);
        count_busy(n);
        chk("R11 program busy length", 8'(n), 8'(PROG_CYC));
        bus_rd(8'h40, v); chk("R4 program AND", v, model[8'h40]);

        // R4 sweep: every address, then AND with a second pattern
        for (int i = 0; i < DEPTH; i++) begin
            prog_start(8'(i), 8'(i) ^ 8'h5A); wait_idle();
        end
        for (int i = 8'h60; i < 8'h80; i++) begin
            prog_start(8'(i), 8'(i * 3)); wait_idle();
        end
        sweep("R4 program sweep");

        // R5 + R9 + R11 erase
        ext_seq(8'h10);
        erase_model();
        bus_rd(8'h10, v); bus_rd(8'h10, v2);
        chk("R9 erase status bit7", {7'b0, v[7]}, 8'h00);
        chk("R9 toggle during erase", {7'b0, v[6] ^ v2[6]}, 8'h01);
        count_busy(n);
        chk("R11 erase busy length", 8'(n + 4), 8'(ERASE_CYC));
        sweep("R5 erase");

        // R9 data polling during program
        prog_start(8'h90, 8'h3C);
        bus_rd(8'h90, v); bus_rd(8'h90, v2);
        chk("R9 poll bit7", {7'b0, v[7]}, 8'h01);
        chk("R9 low bits", {2'b0, v[5:0]}, 8'h00);
        chk("R9 toggle", {7'b0, v[6] ^ v2[6]}, 8'h01);
        wait_idle();
        bus_rd(8'h90, v); chk("R9 true data after", v, 8'h3C);

        // R10 write in last busy cycle ignored
        prog_start(8'h91, 8'h0F);
        repeat (PROG_CYC - 1) @(negedge clk);
        chk("R10 still busy", {7'b0, busy}, 8'h01);
        wr_now(KA, 8'hAA, 1'b1);
        bus_wr(KB, 8'h55); bus_wr(KA, 8'h90);
        bus_rd(8'h00, v); chk("R10 late write dropped", v, model[0]);
        bus_rd(8'h91, v); chk("R10 program landed", v, 8'h0F);
        // one cycle later it is accepted
        prog_start(8'h92, 8'hF0);
        repeat (PROG_CYC) @(negedge clk);
        wr_now(KA, 8'hAA, 1'b1);
        bus_wr(KB, 8'h55); bus_wr(KA, 8'h90);
        bus_rd(8'h00, v); chk("R7 entry after busy", v, 8'h1F);
        bus_wr(8'h33, 8'hF0);
        bus_rd(8'h00, v); chk("R8 single F0 exit", v, model[0]);

        // R3 broken sequences
        bus_wr(KA, 8'hAA); bus_wr(KB, 8'h55); bus_wr(KA, 8'h77);
        bus_wr(KA, 8'hA0); bus_wr(8'h95, 8'h00);
        chk("R3 no busy after break", {7'b0, busy}, 8'h00);
        bus_rd(8'h95, v); chk("R3 break leaves byte", v, model[8'h95]);
        bus_wr(8'h54, 8'hAA); bus_wr(KB, 8'h55); bus_wr(KA, 8'hA0); bus_wr(8'h96, 8'h00);
        bus_rd(8'h96, v); chk("R3 wrong key address", v, model[8'h96]);

        // R1 write with oe_n low is not taken; arm still pending
        bus_wr(KA, 8'hAA); bus_wr(KB, 8'h55); bus_wr(KA, 8'hA0);
        @(negedge clk); wr_now(8'h97, 8'h00, 1'b0);
        chk("R1 inhibited write no busy", {7'b0, busy}, 8'h00);
        bus_rd(8'h97, v); chk("R1 inhibited write", v, model[8'h97]);
        bus_wr(8'h97, 8'h81); model[8'h97] = model[8'h97] & 8'h81;
        wait_idle();
        bus_rd(8'h97, v); chk("R1 armed program still pending", v, model[8'h97]);

        // R7 identification sweep
        id_enter();
        for (int i = 0; i < 8; i++) begin
            bus_rd(8'(i), v);
            chk("R7 id read", v, (i == 0) ? 8'h1F : (i == 1) ? 8'h13 : 8'h00);
        end
        bus_wr(KA, 8'hAA); bus_wr(KB, 8'h55); bus_wr(KA, 8'hF0);
        bus_rd(8'h01, v); chk("R8 keyed exit", v, model[1]);
        id_enter();
        bus_wr(8'h40, 8'h12);
        bus_rd(8'h40, v); chk("R8 stray write exits unchanged", v, model[8'h40]);

        // R6 lockout
        prog_start(8'h05, 8'h0F); wait_idle();
        ext_seq(8'h40);
        lock_m = 1'b1;
        @(negedge clk);
        chk("R6 lock has no busy", {7'b0, busy}, 8'h00);
        id_enter();
        bus_rd(8'h02, v); chk("R6 R7 lock flag", v, 8'h01);
        bus_wr(8'h00, 8'hF0);
        prog_start(8'h05, 8'h00); wait_idle();
        bus_rd(8'h05, v); chk("R6 boot program blocked", v, 8'h0F);
        prog_start(8'h20, 8'h00); wait_idle();
        bus_rd(8'h20, v); chk("R6 main program allowed", v, 8'h00);
        ext_seq(8'h10); erase_model(); wait_idle();
        sweep("R6 erase spares boot");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule